// File: doc/BRIEF.md
# Secure and Privileged Register Access Filter

This block guards a bank of power-control register fields against accesses that lack the right attributes. Every bus request carries a secure flag and a privileged flag. For each bit of the addressed word, the filter decides in the same cycle whether a write may change the bit and whether a read may return the stored value. A bit that is refused reads as zero and keeps its old value on a write. No error is ever signalled.

The decision draws on a global isolation enable input, a per-item security configuration register, and a privilege configuration register with two bits. One bit locks secure items to privileged code. The other does the same for items left non-secure. A bank bit belongs to item `b mod N_ITEMS`, where `b` is its bit position. The bank itself is a plain array of registers.

Address map: 0 is the security configuration register, 1 is the privilege configuration register, and 2 to `N_REGS+1` are the bank registers. Any higher address is unmapped. Defaults: 16-bit data, 4 items, 4 bank registers (addresses 2 to 5), and a 3-bit address.

Top module: `pwr_access_filter`

## Requirements
- R1: When isolation is enabled and `seccfg[b mod N_ITEMS]` is 1, bank bit b is a secure bit. A non-secure write leaves it unchanged, and a non-secure read returns 0 in its position.
- R2: With `tz_en_i` low, the security configuration register (address 0) reads 0 and ignores writes, and every bank bit is treated as non-secure. With `tz_en_i` high, only secure writes change the security configuration register.
- R3: After reset, the security configuration, privilege configuration and all bank registers are 0. Any attribute combination can then read and write the bank.
- R4: The privilege configuration register is at address 1, with bit 0 = secure-privilege lock and bit 1 = non-secure-privilege lock, all other bits reading 0. Any access can read it, and an unprivileged write to it has no effect.
- R5: The secure-privilege lock bit changes only through a write that is both secure and privileged.
- R6: The non-secure-privilege lock bit changes through any privileged write, secure or non-secure.
- R7: While the secure-privilege lock is set, secure bank bits and security configuration bits can be written and read only by privileged secure accesses. The security configuration and privilege configuration registers stay readable by unprivileged accesses.
- R8: While the non-secure-privilege lock is set, non-secure bank bits can be read and written only by privileged accesses. The exception is the status bits, `STAT_MASK` (default bits [1:0]) of the last bank register (address 5), which unprivileged accesses can still read when those bits are non-secure.
- R9: Permission is per bit. In one write, the allowed bits take the write data and the refused bits keep their stored value. A read returns the stored value ANDed with the read mask.
- R10: A read of an unmapped address returns 0 and a write to one changes nothing. `rdata_o` is 0 while `req_i` is low and during write requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tz_en_i | input | 1 | Global isolation enable |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| sec_i | input | 1 | Access is secure |
| priv_i | input | 1 | Access is privileged |
| rdata_o | output | DATA_W | Filtered read data, same cycle |
| wmask_o | output | DATA_W | Per-bit write permission for this request |
| rmask_o | output | DATA_W | Per-bit read permission for this request |

## Verification
The bank is loaded with all-ones words and then overwritten from each of the four secure and privileged attribute pairs. This is done with items split between secure and non-secure (0x5 gives the alternating masks 0x5555 and 0xAAAA). The resulting words show which half of the mask each attribute pair may touch. The same pattern is read back under each lock bit, separately, to tell the secure-side gate apart from the non-secure-side gate. The status-bit exemption is separated from a plain read hole by comparing the status register with an ordinary bank register under the same unprivileged access. Toggling the isolation enable with the security configuration set to all-ones distinguishes "treated as non-secure" from "configuration cleared".

// File: rtl/pwr_filt_pkg.sv
package pwr_filt_pkg;
  localparam int unsigned ADDR_SECCFG  = 0;
  localparam int unsigned ADDR_PRIVCFG = 1;
  localparam int unsigned BANK_BASE    = 2;
  localparam int unsigned SPRIV_BIT    = 0;
  localparam int unsigned NSPRIV_BIT   = 1;
endpackage

// File: rtl/pwr_filt_rule.sv
module pwr_filt_rule
  import pwr_filt_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned N_ITEMS = 4,
  parameter int unsigned N_REGS  = 4,
  parameter int unsigned ADDR_W  = 3,
  parameter logic [DATA_W-1:0] STAT_MASK = '0
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              tz_en_i,
  input  logic              sec_i,
  input  logic              priv_i,
  input  logic [N_ITEMS-1:0] seccfg_i,
  input  logic              spriv_i,
  input  logic              nspriv_i,
  output logic [DATA_W-1:0] wmask_o,
  output logic [DATA_W-1:0] rmask_o
);
  localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(ADDR_SECCFG);
  localparam logic [ADDR_W-1:0] A_PRV  = ADDR_W'(ADDR_PRIVCFG);
  localparam logic [ADDR_W-1:0] A_BANK = ADDR_W'(BANK_BASE);
  localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(BANK_BASE + N_REGS - 1);
  localparam logic [DATA_W-1:0] SEC_IMPL = DATA_W'({N_ITEMS{1'b1}});
  localparam logic [DATA_W-1:0] PRV_IMPL = DATA_W'(2'b11);

  logic sec_ok, ns_ok;
  logic [DATA_W-1:0] bank_w, bank_r, bank_rs;

  assign sec_ok = sec_i & (~spriv_i | priv_i);
  assign ns_ok  = ~nspriv_i | priv_i;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    localparam int unsigned IT = b % N_ITEMS;
    logic item_sec;
    assign item_sec   = tz_en_i & seccfg_i[IT];
    assign bank_w[b]  = item_sec ? sec_ok : ns_ok;
    assign bank_r[b]  = bank_w[b];
    // status bits stay visible on the non-secure side only
    assign bank_rs[b] = item_sec ? sec_ok : (ns_ok | STAT_MASK[b]);
  end

  always_comb begin
    wmask_o = '0;
    rmask_o = '0;
    if (req_i) begin
      if (addr_i == A_SEC) begin
        if (tz_en_i) begin
          if (we_i) wmask_o = sec_ok ? SEC_IMPL : '0;
          else      rmask_o = SEC_IMPL;
        end
      end else if (addr_i == A_PRV) begin
        if (we_i) begin
          wmask_o[SPRIV_BIT]  = sec_i & priv_i;
          wmask_o[NSPRIV_BIT] = priv_i;
        end else begin
          rmask_o = PRV_IMPL;
        end
      end else if (addr_i >= A_BANK && addr_i <= A_LAST) begin
        if (we_i) wmask_o = bank_w;
        else      rmask_o = (addr_i == A_LAST) ? bank_rs : bank_r;
      end
    end
  end
endmodule

// File: rtl/pwr_filt_cfg.sv
module pwr_filt_cfg
  import pwr_filt_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned N_ITEMS = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sec_wr_i,
  input  logic               prv_wr_i,
  input  logic [DATA_W-1:0]  wmask_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [N_ITEMS-1:0] seccfg_o,
  output logic               spriv_o,
  output logic               nspriv_o
);
  logic [N_ITEMS-1:0] wm, wd;
  assign wm = wmask_i[N_ITEMS-1:0];
  assign wd = wdata_i[N_ITEMS-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seccfg_o <= '0;
      spriv_o  <= 1'b0;
      nspriv_o <= 1'b0;
    end else begin
      if (sec_wr_i) seccfg_o <= (seccfg_o & ~wm) | (wd & wm);
      if (prv_wr_i) begin
        if (wmask_i[SPRIV_BIT])  spriv_o  <= wdata_i[SPRIV_BIT];
        if (wmask_i[NSPRIV_BIT]) nspriv_o <= wdata_i[NSPRIV_BIT];
      end
    end
  end
endmodule

// File: rtl/pwr_filt_bank.sv
module pwr_filt_bank #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned N_REGS = 4,
  parameter int unsigned IDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wmask_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] regs_q [N_REGS];

  for (genvar r = 0; r < N_REGS; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[r] <= '0;
      else if (wr_i && idx_i == IDX_W'(r))
        regs_q[r] <= (regs_q[r] & ~wmask_i) | (wdata_i & wmask_i);
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int r = 0; r < N_REGS; r++)
      if (idx_i == IDX_W'(r)) rdata_o = regs_q[r];
  end
endmodule

// File: rtl/pwr_access_filter.sv
module pwr_access_filter
  import pwr_filt_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned N_ITEMS = 4,
  parameter int unsigned N_REGS  = 4,
  parameter logic [DATA_W-1:0] STAT_MASK = DATA_W'(2'b11),
  localparam int unsigned ADDR_W = $clog2(N_REGS + BANK_BASE)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tz_en_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              sec_i,
  input  logic              priv_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] wmask_o,
  output logic [DATA_W-1:0] rmask_o
);
  localparam int unsigned IDX_W = (N_REGS > 1) ? $clog2(N_REGS) : 1;
  localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(ADDR_SECCFG);
  localparam logic [ADDR_W-1:0] A_PRV  = ADDR_W'(ADDR_PRIVCFG);
  localparam logic [ADDR_W-1:0] A_BANK = ADDR_W'(BANK_BASE);
  localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(BANK_BASE + N_REGS - 1);

  logic [N_ITEMS-1:0] seccfg_w;
  logic               spriv_w, nspriv_w;
  logic               wr, bank_hit;
  logic [ADDR_W-1:0]  off;
  logic [DATA_W-1:0]  bank_rd, raw_rd;

  assign wr       = req_i & we_i;
  assign bank_hit = (addr_i >= A_BANK) && (addr_i <= A_LAST);
  assign off      = addr_i - A_BANK;

  pwr_filt_rule #(
    .DATA_W(DATA_W), .N_ITEMS(N_ITEMS), .N_REGS(N_REGS),
    .ADDR_W(ADDR_W), .STAT_MASK(STAT_MASK)
  ) rule_i (
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .tz_en_i(tz_en_i),
    .sec_i(sec_i), .priv_i(priv_i), .seccfg_i(seccfg_w),
    .spriv_i(spriv_w), .nspriv_i(nspriv_w),
    .wmask_o(wmask_o), .rmask_o(rmask_o)
  );

  pwr_filt_cfg #(.DATA_W(DATA_W), .N_ITEMS(N_ITEMS)) cfg_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sec_wr_i(wr && addr_i == A_SEC), .prv_wr_i(wr && addr_i == A_PRV),
    .wmask_i(wmask_o), .wdata_i(wdata_i),
    .seccfg_o(seccfg_w), .spriv_o(spriv_w), .nspriv_o(nspriv_w)
  );

  pwr_filt_bank #(.DATA_W(DATA_W), .N_REGS(N_REGS), .IDX_W(IDX_W)) bank_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr && bank_hit),
    .idx_i(off[IDX_W-1:0]), .wmask_i(wmask_o), .wdata_i(wdata_i),
    .rdata_o(bank_rd)
  );

  always_comb begin
    raw_rd = '0;
    if (addr_i == A_SEC)      raw_rd = DATA_W'(seccfg_w);
    else if (addr_i == A_PRV) raw_rd = DATA_W'({nspriv_w, spriv_w});
    else if (bank_hit)        raw_rd = bank_rd;
  end

  assign rdata_o = raw_rd & rmask_o;
endmodule

// File: rtl/pwr_filt_chk.sv
module pwr_filt_chk #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned N_ITEMS = 4,
  parameter int unsigned N_REGS  = 4,
  parameter int unsigned ADDR_W  = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tz_en_i,
  input logic               req_i,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               sec_i,
  input logic               priv_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic [N_ITEMS-1:0] seccfg_w,
  input logic               spriv_w,
  input logic               nspriv_w
);
  localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(N_REGS + 1);
  logic rd, in_bank;
  assign rd      = req_i && !we_i;
  assign in_bank = (addr_i >= ADDR_W'(2)) && (addr_i <= A_LAST);

  AST_NS_SECURE_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && tz_en_i && !sec_i && in_bank && (&seccfg_w)) |-> rdata_o == '0); // R1
  AST_SECCFG_WI_ISO_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !tz_en_i && addr_i == '0) |=> $stable(seccfg_w)); // R2
  AST_SECCFG_RAZ_ISO_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && !tz_en_i && addr_i == '0) |-> rdata_o == '0); // R2
  AST_PRIVCFG_READABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == ADDR_W'(1)) |-> rdata_o == DATA_W'({nspriv_w, spriv_w})); // R4
  AST_SPRIV_WRITER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(spriv_w) |-> $past(req_i && we_i && addr_i == ADDR_W'(1) && sec_i && priv_i)); // R5
  AST_NSPRIV_WRITER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(nspriv_w) |-> $past(req_i && we_i && addr_i == ADDR_W'(1) && priv_i)); // R6
  AST_SPRIV_SECURE_UNPRIV_RAZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && !priv_i && spriv_w && tz_en_i && in_bank && (&seccfg_w)) |-> rdata_o == '0); // R7
  AST_UNMAPPED_RAZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i > A_LAST) |-> rdata_o == '0); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i || we_i) |-> rdata_o == '0); // R10
endmodule

bind pwr_access_filter pwr_filt_chk #(
  .DATA_W(DATA_W), .N_ITEMS(N_ITEMS), .N_REGS(N_REGS), .ADDR_W(ADDR_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .tz_en_i(tz_en_i), .req_i(req_i), .we_i(we_i),
  .addr_i(addr_i), .sec_i(sec_i), .priv_i(priv_i), .rdata_o(rdata_o),
  .seccfg_w(seccfg_w), .spriv_w(spriv_w), .nspriv_w(nspriv_w)
);

// File: tb/pwr_access_filter_tb.sv
module pwr_access_filter_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tz = 1'b0, req = 1'b0, we = 1'b0, sec = 1'b0, priv = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, wmask, rmask;
  int n_tests = 0, n_fail = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  pwr_access_filter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tz_en_i(tz), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .sec_i(sec), .priv_i(priv),
    .rdata_o(rdata), .wmask_o(wmask), .rmask_o(rmask)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic s, input logic p);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; sec = s; priv = p;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [2:0] a, input logic s, input logic p,
                    input logic [15:0] exp);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a; sec = s; priv = p;
    #1 chk(tag, rdata, exp);
    req = 1'b0;
  endtask

  task automatic set_tz(input logic v);
    @(negedge clk);
    tz = v;
  endtask

  task automatic t_reset;
    rd("R3 seccfg reset", 3'd0, 1, 1, 16'h0000);
    rd("R3 privcfg reset", 3'd1, 1, 1, 16'h0000);
    for (int a = 2; a < 6; a++) rd("R3 bank reset", 3'(a), 0, 0, 16'h0000);
    wr(3'd2, 16'hA5A5, 0, 0);
    rd("R3 unpriv nonsec write", 3'd2, 0, 0, 16'hA5A5);
  endtask

  task automatic t_iso_off;
    wr(3'd0, 16'h000F, 1, 1);
    rd("R2 seccfg ignored when off", 3'd0, 1, 1, 16'h0000);
    set_tz(1);
    rd("R2 seccfg still zero", 3'd0, 1, 1, 16'h0000);
    wr(3'd0, 16'h000F, 1, 1);
    rd("R2 seccfg secure write", 3'd0, 0, 0, 16'h000F);
    wr(3'd0, 16'h0000, 0, 1);
    rd("R2 seccfg nonsec write ignored", 3'd0, 1, 1, 16'h000F);
    set_tz(0);
    rd("R2 seccfg raz when off", 3'd0, 1, 1, 16'h0000);
    wr(3'd3, 16'h1234, 0, 0);
    rd("R2 bank nonsecure when off", 3'd3, 0, 0, 16'h1234);
    set_tz(1);
    rd("R1 all items secure nonsec read", 3'd3, 0, 0, 16'h0000);
    rd("R1 secure read", 3'd3, 1, 0, 16'h1234);
  endtask

  task automatic t_secure_item;
    wr(3'd0, 16'h0005, 1, 1);
    wr(3'd2, 16'hFFFF, 1, 0);
    rd("R1 secure write", 3'd2, 1, 0, 16'hFFFF);
    wr(3'd2, 16'h0000, 0, 1);
    rd("R9 partial write", 3'd2, 1, 0, 16'h5555);
    rd("R1 nonsec read masked", 3'd2, 0, 1, 16'h0000);
  endtask

  task automatic t_privcfg;
    wr(3'd1, 16'h0003, 1, 0);
    rd("R4 unpriv write ignored", 3'd1, 1, 1, 16'h0000);
    wr(3'd1, 16'h0003, 0, 1);
    rd("R5 R6 nonsec priv write", 3'd1, 1, 1, 16'h0002);
    wr(3'd1, 16'h0001, 1, 1);
    rd("R5 secure priv write", 3'd1, 0, 0, 16'h0001);
    wr(3'd1, 16'h0000, 1, 1);
    rd("R6 cleared", 3'd1, 0, 0, 16'h0000);
  endtask

  task automatic t_spriv;
    wr(3'd1, 16'h0001, 1, 1);
    wr(3'd2, 16'h0000, 1, 1);
    wr(3'd2, 16'hFFFF, 1, 0);
    rd("R7 unpriv secure bits blocked", 3'd2, 1, 1, 16'hAAAA);
    wr(3'd2, 16'hFFFF, 1, 1);
    rd("R7 unpriv read masked", 3'd2, 1, 0, 16'hAAAA);
    rd("R7 priv read full", 3'd2, 1, 1, 16'hFFFF);
    wr(3'd0, 16'h0000, 1, 0);
    rd("R7 seccfg unpriv write ignored, readable", 3'd0, 1, 0, 16'h0005);
    rd("R7 privcfg unpriv readable", 3'd1, 0, 0, 16'h0001);
    wr(3'd1, 16'h0000, 1, 1);
  endtask

  task automatic t_nspriv;
    wr(3'd1, 16'h0002, 0, 1);
    wr(3'd5, 16'hFFFF, 1, 1);
    rd("R8 status bit unpriv nonsec", 3'd5, 0, 0, 16'h0002);
    rd("R8 secure unpriv with status", 3'd5, 1, 0, 16'h5557);
    rd("R8 plain reg no exemption", 3'd2, 0, 0, 16'h0000);
    wr(3'd5, 16'h0000, 0, 0);
    rd("R8 unpriv write ignored", 3'd5, 0, 1, 16'hAAAA);
    wr(3'd5, 16'h0000, 0, 1);
    rd("R8 priv write", 3'd5, 1, 1, 16'h5555);
    rd("R8 privcfg unpriv readable", 3'd1, 0, 0, 16'h0002);
    wr(3'd1, 16'h0000, 0, 1);
  endtask

  task automatic t_unmapped;
    wr(3'd6, 16'hFFFF, 1, 1);
    rd("R10 unmapped 6", 3'd6, 1, 1, 16'h0000);
    rd("R10 unmapped 7", 3'd7, 1, 1, 16'h0000);
    rd("R10 bank untouched", 3'd4, 1, 1, 16'h0000);
    @(negedge clk);
    req = 1'b0; addr = 3'd2; sec = 1'b1; priv = 1'b1;
    #1 chk("R10 idle rdata zero", rdata, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_iso_off();
    t_secure_item();
    t_privcfg();
    t_spriv();
    t_nspriv();
    t_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule